// File: doc/BRIEF.md
# Two-wire bus host handshake controller

This block is the processor-facing control layer of a two-wire serial interface. Software reaches it through a small register window: a control register, a bit-rate division register and a data register. The bit-level bus timing engine sits beside it. That engine reports events to this block: a job finished, the own address was matched, a general call was seen, a byte was received, a stop condition was sent. In return this block supplies the start and stop requests, the enable, the bit-rate divisor, the byte to transmit, a clock-stretch hold request and a per-event acknowledge decision.

The handshake works like this. When the engine finishes a job, the completion flag rises and the serial clock is held low. Software answers by writing a one into the flag. That clears the flag, releases the hold and pulses a launch strobe, which starts the next bus operation. The data register can be written only while the flag is set. A write at any other time leaves the register unchanged and raises a collision flag.

Top module: `tw_host_ctrl`

## Requirements
- R1: After synchronous reset, the control, rate and data registers read 0x00, and `irq`, `scl_hold`, `ack_out` and `go` are low.
- R2: The control register is at address 0xBC and the rate register at 0xB8. Control bits 6 (ack enable), 5 (start), 4 (stop), 2 (interface enable) and 0 (interrupt enable) read back as written. Bit 3 (collision) ignores writes, and bit 1 always reads 0. The rate register reads back its 8 written bits and drives `bit_rate`. Bit 5 drives `start_req`.
- R3: `ev_job_done` sets control bit 7 (completion flag) only while bit 2 is 1. Writing 0 to bit 7 never changes it.
- R4: A control write with bit 7 = 1 while the flag is set clears the flag and makes `go` high for exactly the following cycle. If `ev_job_done` comes in the same cycle as that write, the flag stays set and `go` stays low.
- R5: `scl_hold` is high exactly while the completion flag is set.
- R6: `irq` is high when the completion flag, control bit 0 and `glb_irq_en` are all 1, and low otherwise.
- R7: A data register write (address 0xBB) while the flag is set stores the byte and clears control bit 3. The same write while the flag is clear sets bit 3 and leaves the data register unchanged.
- R8: In the cycle after an event, `ack_out` is high if ack enable is 1 and the event is one of these: `ev_addr_match`; `ev_gcall` while `gc_enable` is 1; or `ev_rx_byte`. Otherwise `ack_out` is low.
- R9: With ack enable at 0, an address match yields no acknowledge. Once the bit is set again, the next match is acknowledged.
- R10: Control bit 4 clears on `ev_stop_sent`. This clear wins over a software write of 1 in the same cycle.
- R11: `ev_rx_byte` loads `rx_byte` into the data register whatever the flag state, and it leaves control bit 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| glb_irq_en | input | 1 | Global interrupt enable |
| gc_enable | input | 1 | General-call recognition enable |
| ev_job_done | input | 1 | Engine finished its current job |
| ev_addr_match | input | 1 | Own address received |
| ev_gcall | input | 1 | General call received |
| ev_rx_byte | input | 1 | Data byte received in a receiver mode |
| ev_stop_sent | input | 1 | Stop condition sent on the bus |
| rx_byte | input | 8 | Received byte from the engine |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Hold the serial clock low |
| ack_out | output | 1 | Acknowledge decision for the last event |
| go | output | 1 | One-cycle launch of the next operation |
| start_req | output | 1 | Start condition request |
| stop_req | output | 1 | Stop condition request |
| if_enable | output | 1 | Interface enable |
| bit_rate | output | 8 | Bit-rate division factor |
| tx_data | output | 8 | Byte to transmit |

## Verification
Some rules are checked by assertions on every cycle: a launch strobe only follows a real flag clear, a job event on an enabled interface always raises the flag, a blocked data write freezes the data and raises collision, no acknowledge is given while acknowledge is disabled, and an interrupt never appears without the clock hold. Other behaviour only the bench scenarios can show. That covers the register read-back masking and the resumption of acknowledges after re-enable. It also covers the same-cycle races: a job event against a flag-clear write, and a stop-sent event against a stop write.

// File: rtl/tw_host_pkg.sv
package tw_host_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic done;
        logic ack_en;
        logic start;
        logic stop;
        logic enable;
        logic ie;
    } ctrl_t;

    typedef struct packed {
        logic addr_match;
        logic gcall;
        logic rx_byte;
    } evt_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c, input logic wcol);
        pack_ctrl = {c.done, c.ack_en, c.start, c.stop, wcol, c.enable, 1'b0, c.ie};
    endfunction

endpackage

// File: rtl/tw_ctrl_regs.sv
module tw_ctrl_regs
    import tw_host_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_rate,
    input  logic [REG_W-1:0]  wdata,
    input  logic              ev_job_done,
    input  logic              ev_stop_sent,
    output ctrl_t             ctrl,
    output logic [RATE_W-1:0] rate,
    output logic              go
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            rate <= '0;
            go   <= 1'b0;
        end else begin
            go <= 1'b0;
            if (wr_rate) rate <= wdata[RATE_W-1:0];
            if (wr_ctrl) begin
                ctrl.ack_en <= wdata[6];
                ctrl.start  <= wdata[5];
                ctrl.stop   <= wdata[4];
                ctrl.enable <= wdata[2];
                ctrl.ie     <= wdata[0];
            end
            if (ev_stop_sent) ctrl.stop <= 1'b0;
            if (ev_job_done && ctrl.enable) begin
                ctrl.done <= 1'b1;
            end else if (wr_ctrl && wdata[7] && ctrl.done) begin
                ctrl.done <= 1'b0;
                go        <= 1'b1;
            end
        end
    end

    // R4: a launch strobe follows only a genuine flag clear
    a_r4_go_after_clear: assert property (@(posedge clk) disable iff (rst)
        go |-> ($past(ctrl.done) && !ctrl.done));

    // R3: an enabled job event always leaves the flag set
    a_r3_flag_set: assert property (@(posedge clk) disable iff (rst)
        (ev_job_done && ctrl.enable) |=> ctrl.done);

    // R10: stop-sent always leaves the stop request clear
    a_r10_stop_clear: assert property (@(posedge clk) disable iff (rst)
        ev_stop_sent |=> !ctrl.stop);

endmodule

// File: rtl/tw_data_reg.sv
module tw_data_reg
    import tw_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              ev_rx_byte,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] data,
    output logic              wcol
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            wcol <= 1'b0;
        end else if (ev_rx_byte) begin
            data <= rx_byte;
        end else if (wr_data) begin
            if (done) begin
                data <= wdata;
                wcol <= 1'b0;
            end else begin
                wcol <= 1'b1;
            end
        end
    end

    // R7: a write while locked freezes the data and flags a collision
    a_r7_blocked_write: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !done && !ev_rx_byte) |=> (wcol && $stable(data)));

    // R11: a received byte never disturbs the collision flag
    a_r11_rx_keeps_wcol: assert property (@(posedge clk) disable iff (rst)
        ev_rx_byte |=> $stable(wcol));

endmodule

// File: rtl/tw_ack_decide.sv
module tw_ack_decide
    import tw_host_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_en,
    input  logic gc_enable,
    input  evt_t evt,
    output logic ack_out
);

    logic qualify;

    always_comb begin
        qualify = evt.addr_match | (evt.gcall & gc_enable) | evt.rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) ack_out <= 1'b0;
        else     ack_out <= ack_en & qualify;
    end

    // R9: acknowledge disabled means no acknowledge next cycle
    a_r9_no_ack_when_off: assert property (@(posedge clk) disable iff (rst)
        !ack_en |=> !ack_out);

    // R8: an acknowledge only follows some event
    a_r8_ack_has_cause: assert property (@(posedge clk) disable iff (rst)
        ack_out |-> $past(evt.addr_match || evt.gcall || evt.rx_byte));

endmodule

// File: rtl/tw_host_ctrl.sv
module tw_host_ctrl
    import tw_host_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = 8'hBC,
    parameter logic [7:0] RATE_ADDR = 8'hB8,
    parameter logic [7:0] DATA_ADDR = 8'hBB
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       glb_irq_en,
    input  logic       gc_enable,
    input  logic       ev_job_done,
    input  logic       ev_addr_match,
    input  logic       ev_gcall,
    input  logic       ev_rx_byte,
    input  logic       ev_stop_sent,
    input  logic [7:0] rx_byte,
    output logic       irq,
    output logic       scl_hold,
    output logic       ack_out,
    output logic       go,
    output logic       start_req,
    output logic       stop_req,
    output logic       if_enable,
    output logic [7:0] bit_rate,
    output logic [7:0] tx_data
);

    localparam int RATE_W = REG_W;
    localparam int DATA_W = REG_W;

    ctrl_t ctrl;
    evt_t  evt;
    logic  wcol;
    logic  wr_ctrl, wr_rate, wr_data;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
        wr_rate = bus_wr && (bus_addr == RATE_ADDR);
        wr_data = bus_wr && (bus_addr == DATA_ADDR);
        evt = '{addr_match: ev_addr_match, gcall: ev_gcall, rx_byte: ev_rx_byte};
    end

    tw_ctrl_regs #(.RATE_W(RATE_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_ctrl      (wr_ctrl),
        .wr_rate      (wr_rate),
        .wdata        (bus_wdata),
        .ev_job_done  (ev_job_done),
        .ev_stop_sent (ev_stop_sent),
        .ctrl         (ctrl),
        .rate         (bit_rate),
        .go           (go)
    );

    tw_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst        (rst),
        .wr_data    (wr_data),
        .wdata      (bus_wdata),
        .done       (ctrl.done),
        .ev_rx_byte (ev_rx_byte),
        .rx_byte    (rx_byte),
        .data       (tx_data),
        .wcol       (wcol)
    );

    tw_ack_decide u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack_en    (ctrl.ack_en),
        .gc_enable (gc_enable),
        .evt       (evt),
        .ack_out   (ack_out)
    );

    always_comb begin
        case (bus_addr)
            CTRL_ADDR: bus_rdata = pack_ctrl(ctrl, wcol);
            RATE_ADDR: bus_rdata = bit_rate;
            DATA_ADDR: bus_rdata = tx_data;
            default:   bus_rdata = '0;
        endcase
        irq       = ctrl.done & ctrl.ie & glb_irq_en;
        scl_hold  = ctrl.done;
        start_req = ctrl.start;
        stop_req  = ctrl.stop;
        if_enable = ctrl.enable;
    end

    // R6: an interrupt is never raised without the clock being held
    a_r6_irq_needs_hold: assert property (@(posedge clk) disable iff (rst)
        irq |-> scl_hold);

    // R5: the hold drops only together with a launch strobe
    a_r5_hold_release: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_hold) |-> go);

endmodule

// File: tb/tw_host_ctrl_bench.sv
module tw_host_ctrl_bench;

    localparam logic [7:0] A_CTRL = 8'hBC;
    localparam logic [7:0] A_RATE = 8'hB8;
    localparam logic [7:0] A_DATA = 8'hBB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       glb_irq_en = 1'b0;
    logic       gc_enable = 1'b0;
    logic       ev_job_done = 1'b0;
    logic       ev_addr_match = 1'b0;
    logic       ev_gcall = 1'b0;
    logic       ev_rx_byte = 1'b0;
    logic       ev_stop_sent = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       irq, scl_hold, ack_out, go, start_req, stop_req, if_enable;
    logic [7:0] bit_rate, tx_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tw_host_ctrl u_tw_host_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glb_irq_en(glb_irq_en),
        .gc_enable(gc_enable), .ev_job_done(ev_job_done),
        .ev_addr_match(ev_addr_match), .ev_gcall(ev_gcall),
        .ev_rx_byte(ev_rx_byte), .ev_stop_sent(ev_stop_sent), .rx_byte(rx_byte),
        .irq(irq), .scl_hold(scl_hold), .ack_out(ack_out), .go(go),
        .start_req(start_req), .stop_req(stop_req), .if_enable(if_enable),
        .bit_rate(bit_rate), .tx_data(tx_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        ev_job_done = 0; ev_addr_match = 0; ev_gcall = 0;
        ev_rx_byte = 0; ev_stop_sent = 0; bus_wr = 0;
    endtask

    task automatic t_reset;
        chk_reg("R1 ctrl", A_CTRL, 8'h00);
        chk_reg("R1 rate", A_RATE, 8'h00);
        chk_reg("R1 data", A_DATA, 8'h00);
        chk("R1 outs", {4'b0, irq, scl_hold, ack_out, go}, 8'h00);
    endtask

    task automatic t_regs;
        wr(A_CTRL, 8'h7F);
        chk_reg("R2 ctrl mask", A_CTRL, 8'h75);
        chk("R2 start_req", {7'b0, start_req}, 8'h01);
        wr(A_RATE, 8'hA5);
        chk_reg("R2 rate", A_RATE, 8'hA5);
        chk("R2 bit_rate", bit_rate, 8'hA5);
        wr(A_CTRL, 8'h00);
        chk_reg("R2 ctrl clear", A_CTRL, 8'h00);
    endtask

    task automatic t_flag;
        ev_job_done = 1; tick;
        chk_reg("R3 disabled ignore", A_CTRL, 8'h00);
        wr(A_CTRL, 8'h04);
        ev_job_done = 1; tick;
        chk_reg("R3 flag set", A_CTRL, 8'h84);
        chk("R5 hold on", {7'b0, scl_hold}, 8'h01);
        wr(A_CTRL, 8'h05);
        chk_reg("R3 write0 keeps", A_CTRL, 8'h85);
    endtask

    task automatic t_irq;
        chk("R6 irq no global", {7'b0, irq}, 8'h00);
        glb_irq_en = 1; #1;
        chk("R6 irq on", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_clear_and_collision;
        wr(A_DATA, 8'h3C);
        chk_reg("R7 data stored", A_DATA, 8'h3C);
        wr(A_CTRL, 8'h85);
        chk("R4 go pulse", {7'b0, go}, 8'h01);
        chk_reg("R4 flag cleared", A_CTRL, 8'h05);
        chk("R5 hold off", {6'b0, scl_hold, irq}, 8'h00);
        tick;
        chk("R4 go single", {7'b0, go}, 8'h00);
        wr(A_DATA, 8'h99);
        chk_reg("R7 data frozen", A_DATA, 8'h3C);
        chk_reg("R7 collision set", A_CTRL, 8'h0D);
        ev_job_done = 1; tick;
        wr(A_DATA, 8'h42);
        chk_reg("R7 collision cleared", A_CTRL, 8'h85);
        chk_reg("R7 data new", A_DATA, 8'h42);
    endtask

    task automatic t_race;
        bus_addr = A_CTRL; bus_wdata = 8'h85; bus_wr = 1; ev_job_done = 1;
        tick;
        chk_reg("R4 set wins", A_CTRL, 8'h85);
        chk("R4 no go on race", {7'b0, go}, 8'h00);
    endtask

    task automatic t_ack;
        wr(A_CTRL, 8'h45);
        ev_addr_match = 1; tick;
        chk("R8 ack match", {7'b0, ack_out}, 8'h01);
        tick;
        chk("R8 ack drops", {7'b0, ack_out}, 8'h00);
        ev_gcall = 1; tick;
        chk("R8 gcall no enable", {7'b0, ack_out}, 8'h00);
        gc_enable = 1; ev_gcall = 1; tick;
        chk("R8 gcall enabled", {7'b0, ack_out}, 8'h01);
        rx_byte = 8'h5A; ev_rx_byte = 1; tick;
        chk("R8 ack rx", {7'b0, ack_out}, 8'h01);
        chk_reg("R11 rx loaded", A_DATA, 8'h5A);
        chk_reg("R11 wcol kept", A_CTRL, 8'hC5);
        wr(A_CTRL, 8'h05);
        ev_addr_match = 1; tick;
        chk("R9 disconnected", {7'b0, ack_out}, 8'h00);
        wr(A_CTRL, 8'h45);
        ev_addr_match = 1; tick;
        chk("R9 resumed", {7'b0, ack_out}, 8'h01);
    endtask

    task automatic t_stop;
        wr(A_CTRL, 8'h55);
        chk("R10 stop_req set", {7'b0, stop_req}, 8'h01);
        ev_stop_sent = 1; tick;
        chk_reg("R10 stop cleared", A_CTRL, 8'hC5);
        bus_addr = A_CTRL; bus_wdata = 8'h55; bus_wr = 1; ev_stop_sent = 1;
        tick;
        chk_reg("R10 clear wins", A_CTRL, 8'hC5);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset;
        t_regs;
        t_flag;
        t_irq;
        t_clear_and_collision;
        t_race;
        t_ack;
        t_stop;
        finished = 1;
        summary;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary;
        end
    end

endmodule